// File: doc/BRIEF.md
# Selectable-Ratio Reference Divider

This block brings a reference oscillator clock down to the rate at which a phase comparator works. A three-bit select input picks one of eight fixed divide ratios. Seven are binary: 8 and every power of two from 64 to 2048. The eighth is 1160. The ratios are not programmed from outside. A small read-only decoder inside the block computes them and loads them into a 12-bit down-counter.

The counter emits one single-cycle output pulse for each complete divide cycle, so the pulse rate is the reference rate divided by the selected ratio. A new select value is sampled only when the counter wraps. Changing the select inputs therefore never cuts a period short or stretches it. Select lines that are left undriven sit at logic one, and the all-ones code gives the slowest rate.

Top module: `ref_rate_divider`

## Requirements
- R1: Select code 3'b000 produces one output pulse every 8 clock cycles.
- R2: Select codes 3'b001, 3'b010, 3'b011, 3'b100 and 3'b101 produce pulse periods of 64, 128, 256, 512 and 1024 clock cycles respectively.
- R3: Select code 3'b110 produces a pulse period of 1160 clock cycles, which is not a power of two.
- R4: Select code 3'b111, the level that undriven select lines rest at, produces a pulse period of 2048 clock cycles.
- R5: Each output pulse is high for exactly one clock cycle.
- R6: With the default registered output, the first pulse after reset is high in the cycle that follows the R-th rising edge after the last reset edge, where R is the selected ratio.
- R7: A change of select during a period leaves that period's length unchanged. The new ratio governs the period that starts at the next wrap.
- R8: An active-high synchronous reset holds the output low and reloads the counter from the ratio that is selected at that edge.
- R9: The 12-bit counter never holds a value above the selected ratio minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_sel | input | 3 | Divide ratio select code |
| cmp_tick | output | 1 | One-cycle pulse per completed divide cycle |

## Verification
Every select code is run from reset. For each one the bench measures two intervals: the delay from reset to the first pulse, and the gap between two later pulses. A code that has been mapped to the wrong table entry therefore shows up, and so does an off-by-one load, which moves both intervals by one cycle. A select change in the middle of a period separates correct sampling at the wrap from a design that reloads as soon as the select changes. A reset applied mid-run with a different code confirms that the reset picks up the live select value rather than the value that was loaded earlier.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
   localparam int unsigned REFDIV_SEL_W   = 3;
   localparam int unsigned REFDIV_ENTRIES = 1 << REFDIV_SEL_W;
   localparam int unsigned REFDIV_ODD     = 1160;
   localparam int unsigned REFDIV_MAX     = 2048;

   typedef enum logic {
      TICK_REGISTERED = 1'b0,
      TICK_DIRECT     = 1'b1
   } tick_mode_e;

   // Ratio for a select code: 8, then 64<<(code-1), then the odd entry, then 2048.
   function automatic int unsigned refdiv_ratio(int unsigned code);
      int unsigned r;
      case (code)
         0:       r = 8;
         6:       r = REFDIV_ODD;
         7:       r = REFDIV_MAX;
         default: r = 32 << code;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/refdiv_ratio_rom.sv
module refdiv_ratio_rom
   import refdiv_pkg::*;
#(
   parameter int unsigned SEL_W = REFDIV_SEL_W,
   parameter int unsigned CNT_W = 12
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] load_val
);
   localparam int unsigned ENTRIES = 1 << SEL_W;

   generate
      if (SEL_W != REFDIV_SEL_W) begin : g_bad_sel
         $error("refdiv_ratio_rom: SEL_W must be %0d", REFDIV_SEL_W);
      end
      if (CNT_W < $clog2(REFDIV_MAX)) begin : g_bad_cnt
         $error("refdiv_ratio_rom: CNT_W too narrow for largest ratio");
      end
   endgenerate

   logic [CNT_W-1:0] table_q [ENTRIES];

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
         assign table_q[i] = CNT_W'(refdiv_ratio(i) - 1);
      end
   endgenerate

   assign load_val = table_q[sel];
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
   import refdiv_pkg::*;
#(
   parameter int unsigned CNT_W     = 12,
   parameter tick_mode_e  TICK_MODE = TICK_REGISTERED
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] load_val,
   output logic             tick
);
   localparam logic [CNT_W-1:0] MAX_LOAD = CNT_W'(REFDIV_MAX - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst || wrap) cnt_q <= load_val;
      else             cnt_q <= cnt_q - 1'b1;
   end

   generate
      if (TICK_MODE == TICK_REGISTERED) begin : g_reg
         logic tick_q;
         always_ff @(posedge clk) begin
            if (rst) tick_q <= 1'b0;
            else     tick_q <= wrap;
         end
         assign tick = tick_q;

         a_r6_tick_after_wrap: assert property (@(posedge clk) disable iff (rst)
            wrap |=> tick);
         a_r8_quiet_in_reset: assert property (@(posedge clk)
            rst |=> !tick);
      end else begin : g_dir
         assign tick = wrap;
      end
   endgenerate

   a_r5_tick_one_cycle: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
   a_r8_reset_loads: assert property (@(posedge clk)
      rst |=> (cnt_q == $past(load_val)));
   a_r7_steady_descent: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> (cnt_q == $past(cnt_q) - 1'b1));
   a_r7_reload_at_wrap: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (cnt_q == $past(load_val)));
   a_r9_bounded: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= MAX_LOAD);
endmodule

// File: rtl/ref_rate_divider.sv
module ref_rate_divider
   import refdiv_pkg::*;
#(
   parameter int unsigned SEL_W     = REFDIV_SEL_W,
   parameter int unsigned CNT_W     = 12,
   parameter tick_mode_e  TICK_MODE = TICK_REGISTERED
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] ref_sel,
   output logic             cmp_tick
);
   logic [CNT_W-1:0] load_val;

   refdiv_ratio_rom #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_rom (
      .sel      (ref_sel),
      .load_val (load_val)
   );

   refdiv_counter #(.CNT_W(CNT_W), .TICK_MODE(TICK_MODE)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load_val (load_val),
      .tick     (cmp_tick)
   );
endmodule

// File: tb/ref_rate_divider_test.sv
module ref_rate_divider_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] ref_sel = 3'b111;
   logic       cmp_tick;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ref_rate_divider uut (
      .clk(clk), .rst(rst), .ref_sel(ref_sel), .cmp_tick(cmp_tick)
   );

   function automatic int exp_ratio(int code);
      case (code)
         0: return 8;    1: return 64;   2: return 128;  3: return 256;
         4: return 512;  5: return 1024; 6: return 1160; default: return 2048;
      endcase
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Reset for `len` cycles with select `s`, then release; tick must stay low.
   task automatic do_reset(int s, int len);
      @(negedge clk);
      rst = 1'b1; ref_sel = 3'(s);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         check("R8 tick low in reset", int'(cmp_tick), 0);
      end
      rst = 1'b0;
   endtask

   // Count negedges until tick is seen high.
   task automatic wait_tick(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!cmp_tick && n < 5000);
   endtask

   task automatic run_code(string req, int s);
      int n;
      do_reset(s, 1);
      wait_tick(n);
      check({req, " R6 first pulse"}, n, exp_ratio(s));
      @(negedge clk);
      check("R5 pulse width", int'(cmp_tick), 0);
      wait_tick(n);
      check({req, " period"}, n + 1, exp_ratio(s));
   endtask

   task automatic test_sel_change();
      int n;
      do_reset(0, 2);
      repeat (3) @(negedge clk);
      ref_sel = 3'b111;
      wait_tick(n);
      check("R7 period kept after select change", n + 3, 8);
      wait_tick(n);
      check("R7 new ratio next period", n, 2048);
   endtask

   task automatic test_midrun_reset();
      int n;
      do_reset(3, 1);
      repeat (100) @(negedge clk);
      do_reset(6, 3);
      wait_tick(n);
      check("R8 reset loads live select", n, 1160);
   endtask

   initial begin
      run_code("R1", 0);
      run_code("R2", 1);
      run_code("R2", 2);
      run_code("R2", 3);
      run_code("R2", 4);
      run_code("R2", 5);
      run_code("R3", 6);
      run_code("R4", 7);
      test_sel_change();
      test_midrun_reset();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #1500000;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule